// File: doc/BRIEF.md
# Dual-Bank Memory Chip-Select Decoder

This block turns a latched 20-bit byte address into chip selects for a memory built from two byte-wide banks on a 16-bit data path. Even addresses live in the low bank, which drives data bits 7..0. Odd addresses live in the high bank, which drives data bits 15..8. Both banks hold the same number of locations. Two regions are decoded, and each region has one device per bank. A 64 KB RAM region sits at the bottom of the space. A 32 KB ROM region sits at the top, so the ROM answers the processor's start-up address FFFF0h.

A device is enabled only when two conditions hold together. The address must fall in that device's region, and the byte lane must be requested. The low lane is requested by address bit 0 being 0. The high lane is requested by the active-low bus-high-enable input being 0. Address bit 0 never reaches a device; only address bits 1 and up form the internal address inside a bank. An access that is outside both regions raises a miss flag instead. All outputs are registered, so they follow the inputs by one clock.

Top module: `dual_bank_cs_decoder`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all four chip selects are 1 (inactive), `miss` is 0 and `bank_addr` is 0.
- R2: With a strobe active and address 00000h..0FFFFh, only RAM selects may go low, and `bank_addr` equals address bits 15..1.
- R3: With a strobe active and address F8000h..FFFFFh, only ROM selects may go low, and `bank_addr` equals {0, address bits 14..1}.
- R4: A word access (`bhe_n`=0, bit 0=0) drives both the even and the odd select of the hit region low.
- R5: An odd byte access (`bhe_n`=0, bit 0=1) drives only the odd select low.
- R6: An even byte access (`bhe_n`=1, bit 0=0) drives only the even select low. With `bhe_n`=1 and bit 0=1, no select goes low.
- R7: With neither `mem_rd_n` nor `mem_wr_n` low, all selects are 1, `miss` is 0 and `bank_addr` is 0, whatever the address.
- R8: With a strobe active and an address in neither region, `miss` is 1, all selects are 1 and `bank_addr` is 0.
- R9: A RAM select and a ROM select are never low in the same cycle.
- R10: Every output shows the inputs sampled at the previous rising clock edge; it does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 20 | Latched byte address |
| bhe_n | input | 1 | Bus-high-enable, active low; requests the odd lane |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| mem_wr_n | input | 1 | Memory write strobe, active low |
| ram_even_cs_n | output | 1 | RAM low-bank device select, active low |
| ram_odd_cs_n | output | 1 | RAM high-bank device select, active low |
| rom_even_cs_n | output | 1 | ROM low-bank device select, active low |
| rom_odd_cs_n | output | 1 | ROM high-bank device select, active low |
| bank_addr | output | 15 | Address inside the bank (byte address bits 1 and up) |
| miss | output | 1 | Strobed access outside every region |

## Verification
The hardest cases are the region edges. At an edge, one address bit decides between a region hit and a miss. That bit also interacts with the lane qualification, and it can make `bank_addr` pass from all ones to zero. The stimulus steps across 0FFFFh/10000h and F7FFFh/F8000h, and also touches FFFF0h, FFFFFh and an address in the middle of the unmapped gap. Each address is driven with all four combinations of `bhe_n` and bit 0, under both the read strobe and the write strobe. The expected outputs are computed from the requirements one cycle after each input is applied.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

    // Per-bank enable pair, active high inside the block.
    typedef struct packed {
        logic even;
        logic odd;
    } lane_t;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_ROM  = 2'd2
    } region_e;

    localparam int unsigned N_RGN = 2;
    localparam int unsigned IDX_RAM = 0;
    localparam int unsigned IDX_ROM = 1;

    // Lanes requested by one bus cycle: bit 0 low asks for the even bank,
    // bus-high-enable low asks for the odd bank.
    function automatic lane_t lane_request(input logic bhe_n, input logic a0);
        lane_t l;
        l.even = ~a0;
        l.odd  = ~bhe_n;
        return l;
    endfunction

    function automatic lane_t lane_mask(input lane_t l, input logic en);
        lane_t r;
        r.even = l.even & en;
        r.odd  = l.odd & en;
        return r;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dsel_region_match.sv
module dsel_region_match
    import dsel_pkg::*;
#(
    parameter int unsigned     ADDR_W    = 20,
    parameter logic [19:0]     BASE      = 20'h00000,
    parameter int unsigned     SPAN_LOG2 = 16,
    parameter int unsigned     OFF_W     = 15
) (
    input  logic [ADDR_W-2:0] word_addr,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    // word_addr[i] carries byte address bit i+1
    localparam int unsigned TAG_LO = SPAN_LOG2 - 1;

    logic [ADDR_W-1:0] base_full;
    assign base_full = BASE[ADDR_W-1:0];

    always_comb begin
        hit = (word_addr[ADDR_W-2:TAG_LO] == base_full[ADDR_W-1:SPAN_LOG2]);
        off = OFF_W'(word_addr[TAG_LO-1:0]);
    end

endmodule

// File: rtl/dsel_lane_gate.sv
module dsel_lane_gate
    import dsel_pkg::*;
#(
    parameter int unsigned OFF_W = 15
) (
    input  logic             hit,
    input  logic             strobe,
    input  logic             blocked,
    input  lane_t            req,
    input  logic [OFF_W-1:0] off_in,
    output logic             active,
    output lane_t            sel,
    output logic [OFF_W-1:0] off_out
);
    always_comb begin
        active  = hit & strobe & ~blocked;
        sel     = lane_mask(req, active);
        off_out = active ? off_in : '0;
    end

endmodule

// File: rtl/dsel_out_reg.sv
module dsel_out_reg
    import dsel_pkg::*;
#(
    parameter int unsigned OFF_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_t            ram_d,
    input  lane_t            rom_d,
    input  logic             miss_d,
    input  logic [OFF_W-1:0] off_d,
    output lane_t            ram_q,
    output lane_t            rom_q,
    output logic             miss_q,
    output logic [OFF_W-1:0] off_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ram_q  <= '0;
            rom_q  <= '0;
            miss_q <= 1'b0;
            off_q  <= '0;
        end else begin
            ram_q  <= ram_d;
            rom_q  <= rom_d;
            miss_q <= miss_d;
            off_q  <= off_d;
        end
    end

endmodule

// File: rtl/dual_bank_cs_decoder.sv
module dual_bank_cs_decoder
    import dsel_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter logic [19:0] RAM_BASE      = 20'h00000,
    parameter int unsigned RAM_SPAN_LOG2 = 16,
    parameter logic [19:0] ROM_BASE      = 20'hF8000,
    parameter int unsigned ROM_SPAN_LOG2 = 15,
    localparam int unsigned BANK_AW      = max_u(RAM_SPAN_LOG2, ROM_SPAN_LOG2) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               bhe_n,
    input  logic               mem_rd_n,
    input  logic               mem_wr_n,
    output logic               ram_even_cs_n,
    output logic               ram_odd_cs_n,
    output logic               rom_even_cs_n,
    output logic               rom_odd_cs_n,
    output logic [BANK_AW-1:0] bank_addr,
    output logic               miss
);
    logic               strobe;
    lane_t              req;
    logic               hit    [N_RGN];
    logic               active [N_RGN];
    lane_t              sel    [N_RGN];
    logic [BANK_AW-1:0] off_raw[N_RGN];
    logic [BANK_AW-1:0] off_g  [N_RGN];

    logic               miss_d;
    logic [BANK_AW-1:0] off_d;
    lane_t              ram_q, rom_q;

    assign strobe = ~mem_rd_n | ~mem_wr_n;
    assign req    = lane_request(bhe_n, addr[0]);

    for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
        if (g == IDX_RAM) begin : g_ram
            dsel_region_match #(
                .ADDR_W(ADDR_W), .BASE(RAM_BASE),
                .SPAN_LOG2(RAM_SPAN_LOG2), .OFF_W(BANK_AW)
            ) u_match (
                .word_addr(addr[ADDR_W-1:1]), .hit(hit[g]), .off(off_raw[g])
            );
            dsel_lane_gate #(.OFF_W(BANK_AW)) u_gate (
                .hit(hit[g]), .strobe(strobe), .blocked(1'b0), .req(req),
                .off_in(off_raw[g]), .active(active[g]), .sel(sel[g]),
                .off_out(off_g[g])
            );
        end else begin : g_rom
            dsel_region_match #(
                .ADDR_W(ADDR_W), .BASE(ROM_BASE),
                .SPAN_LOG2(ROM_SPAN_LOG2), .OFF_W(BANK_AW)
            ) u_match (
                .word_addr(addr[ADDR_W-1:1]), .hit(hit[g]), .off(off_raw[g])
            );
            // lower region wins if parameters ever make the two overlap
            dsel_lane_gate #(.OFF_W(BANK_AW)) u_gate (
                .hit(hit[g]), .strobe(strobe), .blocked(active[IDX_RAM]),
                .req(req), .off_in(off_raw[g]), .active(active[g]),
                .sel(sel[g]), .off_out(off_g[g])
            );
        end
    end

    always_comb begin
        miss_d = strobe & ~hit[IDX_RAM] & ~hit[IDX_ROM];
        off_d  = off_g[IDX_RAM] | off_g[IDX_ROM];
    end

    dsel_out_reg #(.OFF_W(BANK_AW)) u_oreg (
        .clk(clk), .rst(rst),
        .ram_d(sel[IDX_RAM]), .rom_d(sel[IDX_ROM]),
        .miss_d(miss_d), .off_d(off_d),
        .ram_q(ram_q), .rom_q(rom_q), .miss_q(miss), .off_q(bank_addr)
    );

    assign ram_even_cs_n = ~ram_q.even;
    assign ram_odd_cs_n  = ~ram_q.odd;
    assign rom_even_cs_n = ~rom_q.even;
    assign rom_odd_cs_n  = ~rom_q.odd;

endmodule

// File: rtl/dsel_checker.sv
module dsel_checker #(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned BANK_AW = 15
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  addr,
    input logic               bhe_n,
    input logic               mem_rd_n,
    input logic               mem_wr_n,
    input logic               ram_even_cs_n,
    input logic               ram_odd_cs_n,
    input logic               rom_even_cs_n,
    input logic               rom_odd_cs_n,
    input logic [BANK_AW-1:0] bank_addr,
    input logic               miss
);
    logic any_ram, any_rom, all_high;
    assign any_ram  = ~ram_even_cs_n | ~ram_odd_cs_n;
    assign any_rom  = ~rom_even_cs_n | ~rom_odd_cs_n;
    assign all_high = ram_even_cs_n & ram_odd_cs_n & rom_even_cs_n & rom_odd_cs_n;

    // R9: never two regions at once
    a_r9_one_region: assert property (@(posedge clk) disable iff (rst)
        !(any_ram && any_rom));

    // R8: a miss never comes with a select
    a_r8_miss_no_cs: assert property (@(posedge clk) disable iff (rst)
        miss |-> all_high);

    // R7: no strobe in the previous cycle means idle outputs
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_rd_n) && $past(mem_wr_n)) |-> (all_high && !miss && bank_addr == '0));

    // R5: an odd select needs bus-high-enable in the sampled cycle
    a_r5_odd_needs_bhe: assert property (@(posedge clk) disable iff (rst)
        (!ram_odd_cs_n || !rom_odd_cs_n) |-> !$past(bhe_n));

    // R6: an even select needs address bit 0 low in the sampled cycle
    a_r6_even_needs_a0: assert property (@(posedge clk) disable iff (rst)
        (!ram_even_cs_n || !rom_even_cs_n) |-> !$past(addr[0]));

endmodule

bind dual_bank_cs_decoder dsel_checker #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) u_dsel_chk (
    .clk(clk), .rst(rst), .addr(addr), .bhe_n(bhe_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .ram_even_cs_n(ram_even_cs_n), .ram_odd_cs_n(ram_odd_cs_n),
    .rom_even_cs_n(rom_even_cs_n), .rom_odd_cs_n(rom_odd_cs_n),
    .bank_addr(bank_addr), .miss(miss)
);

// File: tb/tb_dual_bank_cs_decoder.sv
module tb_dual_bank_cs_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        mem_rd_n = 1'b1;
    logic        mem_wr_n = 1'b1;
    logic        ram_even_cs_n, ram_odd_cs_n, rom_even_cs_n, rom_odd_cs_n;
    logic [14:0] bank_addr;
    logic        miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_cs_decoder dut (
        .clk(clk), .rst(rst), .addr(addr), .bhe_n(bhe_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .ram_even_cs_n(ram_even_cs_n), .ram_odd_cs_n(ram_odd_cs_n),
        .rom_even_cs_n(rom_even_cs_n), .rom_odd_cs_n(rom_odd_cs_n),
        .bank_addr(bank_addr), .miss(miss)
    );

    // packed view: {ram_e, ram_o, rom_e, rom_o, miss, bank_addr}
    function automatic logic [19:0] observed();
        return {ram_even_cs_n, ram_odd_cs_n, rom_even_cs_n, rom_odd_cs_n, miss, bank_addr};
    endfunction

    function automatic logic [19:0] model(logic [19:0] a, logic bh, logic rd, logic wr);
        logic stb, in_ram, in_rom, le, lo;
        stb    = !rd || !wr;
        in_ram = a <= 20'h0FFFF;
        in_rom = a >= 20'hF8000;
        le     = !a[0];
        lo     = !bh;
        if (!stb)   return {4'b1111, 1'b0, 15'd0};
        if (in_ram) return {!le, !lo, 2'b11, 1'b0, a[15:1]};
        if (in_rom) return {2'b11, !le, !lo, 1'b0, 1'b0, a[14:1]};
        return {4'b1111, 1'b1, 15'd0};
    endfunction

    task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [19:0] a, logic bh, logic rd, logic wr);
        @(negedge clk);
        addr = a; bhe_n = bh; mem_rd_n = rd; mem_wr_n = wr;
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1;
        drive(20'h00000, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        check("R1 during reset", observed(), {4'b1111, 1'b0, 15'd0});
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 after reset", observed(), {4'b1111, 1'b0, 15'd0});
    endtask

    // R7
    task automatic t_idle();
        logic [19:0] al [3] = '{20'h00010, 20'hFFFF0, 20'h40000};
        foreach (al[i]) begin
            drive(al[i], 1'b0, 1'b1, 1'b1);
            @(posedge clk); #1;
            check("R7 no strobe", observed(), {4'b1111, 1'b0, 15'd0});
        end
    endtask

    // R2..R6, R8, R9 across edges, all lane combinations, read and write
    task automatic t_sweep();
        logic [19:0] al [12] = '{20'h00000, 20'h0FFFE, 20'h0FFFF, 20'h10000,
                                 20'h10001, 20'hF7FFE, 20'hF7FFF, 20'hF8000,
                                 20'hF8001, 20'hFFFF0, 20'hFFFFF, 20'h80000};
        foreach (al[i]) begin
            for (int k = 0; k < 8; k++) begin
                logic [19:0] a;
                logic bh, rd, wr;
                logic [19:0] e;
                string tag, ltag;
                a  = {al[i][19:1], k[0]};
                bh = k[1];
                rd = k[2];
                wr = !k[2];
                drive(a, bh, rd, wr);
                @(posedge clk); #1;
                e = model(a, bh, rd, wr);
                ltag = (!bh && !a[0]) ? "R4" : (!bh ? "R5" : "R6");
                if (e[15]) tag = "R8 miss";
                else if (a <= 20'h0FFFF) tag = {"R2 ram ", ltag};
                else tag = {"R3 rom ", ltag};
                check(tag, observed(), e);
                check("R9 single region",
                      {19'd0, (!ram_even_cs_n || !ram_odd_cs_n) && (!rom_even_cs_n || !rom_odd_cs_n)},
                      20'd0);
            end
        end
    endtask

    // R10: output holds until the next rising edge
    task automatic t_latency();
        drive(20'h02468, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        drive(20'hFC00A, 1'b0, 1'b1, 1'b0);
        #1;
        check("R10 holds before edge", observed(), model(20'h02468, 1'b0, 1'b0, 1'b1));
        @(posedge clk); #1;
        check("R10 updates after edge", observed(), model(20'hFC00A, 1'b0, 1'b1, 1'b0));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle();
        t_sweep();
        t_latency();
        drive(20'h00000, 1'b1, 1'b1, 1'b1);
        @(posedge clk); #1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule